// File: doc/BRIEF.md
# Luma Six-Tap Quarter-Pel Interpolator

This block takes one row of 8-bit integer luma reference samples and produces fractional-position predictors along that row. A six-sample sliding window moves over the incoming stream. For every integer position that has two samples of margin on its left and three on its right, the block computes the half-pel sample between that position and its right-hand neighbour. In the same pass it also computes the two quarter-pel samples on either side of the half-pel point. A per-sample fractional selector chooses which of the four values goes to the output: the integer sample, the left quarter, the half or the right quarter. The filter uses adders and shifts only. The inner term `4(G+H) - (F+I)` is formed once, and its times-one and times-four copies are then summed with the outer pair.

Samples enter on a valid/ready stream that carries a row-end marker. Predictors leave on a second valid/ready stream from a single output register. An input sample is accepted in any cycle where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. This means a stalled consumer stops the input, and a consumer that is always ready gives one predictor per accepted sample with no bubbles. A row of N samples (N up to the row limit, 13 by default) yields N-5 predictors. This covers blocks from 4 to 8 wide together with the filter margin. The window is cleared after the sample that carries `s_last`.

Top module: `luma_qpel_interp`

## Requirements
- R1: While reset is applied and directly after it, `m_valid` is low and `s_ready` is high.
- R2: With `s_frac` = 2, the output is the half-pel value b = clip(0..255, (E - 5F + 20G + 20H - 5I + J + 16) >> 5). E..J are the six most recent samples of the row, and J is the sample just accepted.
- R3: With `s_frac` = 1, the output is (G + b + 1) >> 1, where b is the clipped half-pel value.
- R4: With `s_frac` = 3, the output is (H + b + 1) >> 1, where b is the clipped half-pel value.
- R5: With `s_frac` = 0, the output is the integer sample G, which is the sample accepted three before the current one. Only the encodings 0..3 exist.
- R6: The first five samples of a row produce no output. Each later sample loads exactly one predictor, in arrival order, and `s_frac` is taken together with that sample. A row of 5 or fewer samples produces nothing.
- R7: The sample that carries `s_last` ends the row. The next accepted sample starts a fresh five-sample fill, and no earlier sample takes part in it.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold their values. `s_ready` equals `!m_valid || m_ready`, so no predictor is lost or overwritten.
- R9: With `m_ready` held high, a row is accepted at one sample per clock with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample this cycle |
| s_data | input | DW | Integer reference sample |
| s_last | input | 1 | Marks the final sample of a row |
| s_frac | input | 2 | Position selector taken with the sample: 0 integer, 1 left quarter, 2 half, 3 right quarter |
| m_valid | output | 1 | Predictor valid |
| m_ready | input | 1 | Consumer accepts the predictor |
| m_data | output | DW | Selected predictor |

## Verification
The bench builds the block with its default parameters: 8-bit samples and a 13-sample row limit. These defaults reach the longest row (eight predictors from one row) and every corner of the clip range. Fixed patterns drive the half-pel sum above 255 and below zero, and rows of 5, 6, 9 and 13 samples exercise the fill boundary and the clearing of the window at each row end. Phases with the consumer always ready and phases with the consumer stalling at random check both the full-rate path and the hold behaviour under back-pressure.

// File: rtl/luma_qpel_pkg.sv
package luma_qpel_pkg;
  localparam int TAPS = 6;
  localparam int FILL = TAPS - 1;

  typedef enum logic [1:0] {
    POS_INT   = 2'd0,
    POS_LEFT  = 2'd1,
    POS_HALF  = 2'd2,
    POS_RIGHT = 2'd3
  } qpos_e;
endpackage

// File: rtl/qpel_tap_window.sv
module qpel_tap_window
  import luma_qpel_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ROW_MAX = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     last,
  input  logic [DW-1:0]            din,
  output logic [TAPS-1:0][DW-1:0]  win,
  output logic                     complete
);
  localparam int CW = $clog2(ROW_MAX + 1);

  logic [TAPS-2:0][DW-1:0] hist;
  logic [CW-1:0]           fill_q;

  // window as seen with the incoming sample: index 0 newest (J), 5 oldest (E)
  assign win[0] = din;
  for (genvar k = 1; k < TAPS; k++) begin : g_win
    assign win[k] = hist[k-1];
  end

  assign complete = push && (fill_q >= CW'(FILL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist   <= '0;
      fill_q <= '0;
    end else if (push) begin
      hist[0] <= din;
      for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
      if (last)                          fill_q <= '0;
      else if (fill_q < CW'(ROW_MAX))    fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/qpel_six_tap.sv
module qpel_six_tap
  import luma_qpel_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [TAPS-1:0][DW-1:0] win,
  input  qpos_e                   pos,
  output logic [DW-1:0]           pel
);
  localparam int SW = DW + 8;
  localparam logic signed [SW-1:0] PMAX = SW'((1 << DW) - 1);
  localparam logic signed [SW-1:0] RND  = SW'(16);

  logic signed [SW-1:0] se, sf, sg, sh, si, sj;
  logic signed [SW-1:0] inner, total, shifted;
  logic [DW-1:0]        half;
  logic [DW:0]          left_sum, right_sum;

  always_comb begin
    se = $signed({{(SW-DW){1'b0}}, win[5]});
    sf = $signed({{(SW-DW){1'b0}}, win[4]});
    sg = $signed({{(SW-DW){1'b0}}, win[3]});
    sh = $signed({{(SW-DW){1'b0}}, win[2]});
    si = $signed({{(SW-DW){1'b0}}, win[1]});
    sj = $signed({{(SW-DW){1'b0}}, win[0]});
    // shared inner term, used once plain and once times four
    inner   = ((sg + sh) <<< 2) - (sf + si);
    total   = (se + sj) + inner + (inner <<< 2) + RND;
    shifted = total >>> 5;
    if (shifted < 0)         half = '0;
    else if (shifted > PMAX) half = PMAX[DW-1:0];
    else                     half = shifted[DW-1:0];
    left_sum  = {1'b0, win[3]} + {1'b0, half} + 1'b1;
    right_sum = {1'b0, win[2]} + {1'b0, half} + 1'b1;
    unique case (pos)
      POS_INT:   pel = win[3];
      POS_LEFT:  pel = left_sum[DW:1];
      POS_HALF:  pel = half;
      POS_RIGHT: pel = right_sum[DW:1];
      default:   pel = half;
    endcase
  end
endmodule

// File: rtl/luma_qpel_interp.sv
module luma_qpel_interp
  import luma_qpel_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ROW_MAX = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  input  logic [1:0]    s_frac,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  logic                    push;
  logic                    complete;
  logic [TAPS-1:0][DW-1:0] win;
  logic [DW-1:0]           pel;
  qpos_e                   pos;

  assign s_ready = !m_valid || m_ready;
  assign push    = s_valid && s_ready;
  assign pos     = qpos_e'(s_frac);

  qpel_tap_window #(.DW(DW), .ROW_MAX(ROW_MAX)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .last     (s_last),
    .din      (s_data),
    .win      (win),
    .complete (complete)
  );

  qpel_six_tap #(.DW(DW)) u_filter (
    .win (win),
    .pos (pos),
    .pel (pel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (complete) begin
      m_valid <= 1'b1;
      m_data  <= pel;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/luma_qpel_interp_chk.sv
module luma_qpel_interp_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic [DW-1:0] s_data,
  input logic          s_last,
  input logic [1:0]    s_frac,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data
);
  logic          acc;
  logic [2:0]    seen;
  logic [DW-1:0] h1, h2, h3;

  assign acc = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      h1 <= '0; h2 <= '0; h3 <= '0;
    end else if (acc) begin
      h1 <= s_data; h2 <= h1; h3 <= h2;
      if (s_last)          seen <= '0;
      else if (seen < 3'd5) seen <= seen + 1'b1;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R8
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);

  // R6
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen < 3'd5) |=> !m_valid);

  // R6
  load_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen == 3'd5) |=> m_valid);

  // R5
  int_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen == 3'd5 && s_frac == 2'd0) |=> (m_data == $past(h3)));
endmodule

bind luma_qpel_interp luma_qpel_interp_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_data  (s_data),
  .s_last  (s_last),
  .s_frac  (s_frac),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data)
);

// File: tb/luma_qpel_interp_bench.sv
module luma_qpel_interp_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          s_last = 1'b0;
  logic [1:0]    s_frac = '0;
  logic          m_valid;
  logic          m_ready = 1'b1;
  logic [DW-1:0] m_data;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int bp_mode = 0;
  int stalls = 0;
  bit done = 0;

  always #4 clk = ~clk;

  luma_qpel_interp u_luma_qpel_interp (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .s_frac(s_frac),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clip8(input int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic int ref_pel(input int e, f, g, h, i, j, input int fr);
    int b;
    b = clip8((e - 5*f + 20*g + 20*h - 5*i + j + 16) >>> 5);
    case (fr)
      0: return g;
      1: return (g + b + 1) / 2;
      2: return b;
      default: return (h + b + 1) / 2;
    endcase
  endfunction

  function automatic int pattern_val(input int pat, input int k);
    case (pat)
      1: return 255;
      2: return ((k % 4) < 2) ? 255 : 0;
      3: return ((k % 6) == 2 || (k % 6) == 3) ? 255 : 0;
      4: return (k * 19) % 256;
      default: return $urandom % 256;
    endcase
  endfunction

  // driver: sends one row, pushes expected predictors into the scoreboard
  task automatic send_row(input int n, input int pat, input int fmode);
    int smp[13];
    for (int k = 0; k < n; k++) begin
      int fr;
      smp[k] = pattern_val(pat, k);
      fr = (fmode < 4) ? fmode : (k % 4);
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = DW'(smp[k]);
      s_frac  = 2'(fr);
      s_last  = (k == n - 1);
      if (k >= 5)
        exp_q.push_back((fr << 8) |
          ref_pel(smp[k-5], smp[k-4], smp[k-3], smp[k-2], smp[k-1], smp[k], fr));
      #1;
      while (!s_ready) begin
        stalls++;
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    #2;
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(m_valid == 1'b0, req, int'(m_valid), 0);
  endtask

  // monitor: pops expected items on each output handshake
  logic          prev_stall = 1'b0;
  logic [DW-1:0] prev_data  = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(m_valid && m_data == prev_data, "R8", int'(m_data), int'(prev_data));
      m_ready = (bp_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      prev_stall = m_valid && !m_ready;
      prev_data  = m_data;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", int'(m_data), -1);
        end else begin
          int item;
          string tag;
          item = exp_q.pop_front();
          case (item >> 8)
            0: tag = "R5";
            1: tag = "R3";
            2: tag = "R2";
            default: tag = "R4";
          endcase
          check(int'(m_data) == (item & 255), tag, int'(m_data), item & 255);
        end
      end
    end
  end

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(m_valid == 1'b0, "R1", int'(m_valid), 0);
    check(s_ready == 1'b1, "R1", int'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(m_valid == 1'b0, "R1", int'(m_valid), 0);
    check(s_ready == 1'b1, "R1", int'(s_ready), 1);

    // R9: full row at full rate, no stalls
    bp_mode = 0;
    stalls = 0;
    send_row(13, 0, 4);
    check(stalls == 0, "R9", stalls, 0);
    drain("R6");

    // clip corners, each position select
    for (int fr = 0; fr < 4; fr++) send_row(13, 2, fr);   // R2 low clip
    for (int fr = 0; fr < 4; fr++) send_row(13, 3, fr);   // R2 high clip
    send_row(9, 1, 4);
    send_row(9, 4, 4);
    drain("R2");

    // R6/R7: short row gives nothing and leaves nothing behind
    send_row(5, 1, 2);
    drain("R6");
    send_row(6, 4, 2);
    drain("R7");
    send_row(3, 0, 1);
    send_row(6, 0, 3);
    drain("R7");

    // R8: random back-pressure
    bp_mode = 1;
    for (int r = 0; r < 12; r++) send_row(6 + (r % 8), r % 5, 4);
    drain("R8");
    bp_mode = 0;
    drain("R6");

    done = 1;
    report();
  end
endmodule